// File: doc/BRIEF.md
# Illegal Memory and I/O Access Detector

This block watches the memory and programmed I/O traffic of a processor subsystem and reports accesses that land in space with nothing behind it. Two address windows can be declared unimplemented; each has its own low and high bound and its own enable. Any enabled window that contains the access address raises the illegal-memory flag. I/O commands are checked against a threshold for each direction: the command field is the upper part of the command word, and everything at or above the first unused value is illegal. A separately enabled, parameter-defined reserved command range is flagged as well.

The block also keeps a global memory-protect flag. Reset sets it, and only one specific I/O command clears it. A mode bit chooses how the write-protect output behaves. It can give a steady level that mirrors the flag, or it can give a one-cycle strobe for each memory write made while the flag is set. Configuration is written through a small select/data register port.

Top module: `mem_io_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_illegal` and `io_illegal` are 0, every window and I/O enable is clear, level mode is selected, the protect flag is set and `wp_out` is 1.
- R2: A memory access (`mem_valid`=1) raises `mem_illegal` one cycle later when window 0 is enabled and lo0 <= `mem_addr` <= hi0, with both bounds included.
- R3: Window 1 is checked on its own bounds and enable, independently of window 0. A disabled window never flags an access, even inside its bounds.
- R4: With I/O detection enabled (control bit 2), an output command (`io_dir`=1) whose field `io_cmd[15:6]` is >= the output threshold raises `io_illegal` one cycle later. A field below the threshold does not.
- R5: An input command (`io_dir`=0) is compared against the input threshold, not the output one.
- R6: With spare-range detection enabled (control bit 3), any command with SPARE_LO <= `io_cmd` <= SPARE_HI is illegal, whether or not bit 2 is set.
- R7: With control bit 2 clear, a command at or above its threshold is not flagged unless R6 applies.
- R8: A valid I/O command equal to CLR_CMD (default 16'h4003) clears the protect flag. No other command clears it, and only reset sets it again.
- R9: In level mode (control bit 4 = 0), `wp_out` equals the protect flag as it was in the previous cycle.
- R10: In strobe mode (control bit 4 = 1), `wp_out` is 1 for exactly the cycle after a valid memory write (`mem_write`=1) made while the flag is set, and 0 otherwise.
- R11: In a cycle with no valid strobe on a path, that path's illegal flag is 0 in the next cycle.
- R12: A configuration write (`cfg_we`=1) selects a register by `cfg_sel`: 0 control (bit0 window 0 enable, bit1 window 1 enable, bits 2 to 4 as above), 1 lo0, 2 hi0, 3 lo1, 4 hi1, 5 output threshold, 6 input threshold. Thresholds take their value from `cfg_wdata[15:6]`. A new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| mem_valid | input | 1 | Memory access strobe |
| mem_write | input | 1 | Memory access is a write |
| mem_addr | input | ADDR_W | Memory access address |
| io_valid | input | 1 | I/O command strobe |
| io_dir | input | 1 | 1 = output command, 0 = input command |
| io_cmd | input | CMD_W | I/O command word |
| mem_illegal | output | 1 | Registered illegal-memory flag |
| io_illegal | output | 1 | Registered illegal-I/O flag |
| wp_out | output | 1 | Write-protect level or strobe |

## Verification
The assertions assume that reset is applied before the first strobe. They also assume that `mem_write` and `io_dir` are only meaningful while their strobe is high, so the strobe-mode check reads the write event only through `mem_valid`. Window bounds with lo > hi simply match nothing, and no assertion depends on the bound order. The stimulus changes inputs only one time unit after each rising edge and keeps control bits above 4 at zero. Random addresses and commands are biased toward the programmed bounds and thresholds, so the inclusive edges are hit often.

// File: rtl/mig_pkg.sv
package mig_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_LO0    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_HI0    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_LO1    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_HI1    = 3'd4;
  localparam logic [SEL_W-1:0] SEL_THR_OUT = 3'd5;
  localparam logic [SEL_W-1:0] SEL_THR_IN  = 3'd6;

  typedef struct packed {
    logic strobe_mode;
    logic spare_en;
    logic io_en;
    logic win1_en;
    logic win0_en;
  } guard_ctrl_t;
endpackage

// File: rtl/mig_window.sv
module mig_window #(
  parameter int ADDR_W = 20
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb begin
    hit = en && (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/mig_io_check.sv
module mig_io_check #(
  parameter int CMD_W = 16,
  parameter int FIELD_LSB = 6,
  parameter logic [CMD_W-1:0] SPARE_LO = 16'h4800,
  parameter logic [CMD_W-1:0] SPARE_HI = 16'h4FFF,
  localparam int FIELD_W = CMD_W - FIELD_LSB
) (
  input  logic               io_en,
  input  logic               spare_en,
  input  logic               dir_out,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [FIELD_W-1:0] thr_out,
  input  logic [FIELD_W-1:0] thr_in,
  output logic               illegal
);
  logic [FIELD_W-1:0] field;
  logic [FIELD_W-1:0] thr_sel;
  logic               over_thr;
  logic               in_spare;

  always_comb begin
    field    = cmd[CMD_W-1:FIELD_LSB];
    thr_sel  = dir_out ? thr_out : thr_in;
    over_thr = io_en && (field >= thr_sel);
    in_spare = spare_en && (cmd >= SPARE_LO) && (cmd <= SPARE_HI);
    illegal  = over_thr || in_spare;
  end
endmodule

// File: rtl/mig_protect.sv
module mig_protect (
  input  logic clk,
  input  logic rst,
  input  logic clr_cmd,
  input  logic strobe_mode,
  input  logic wr_evt,
  output logic prot_flag,
  output logic wp_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_flag <= 1'b1;
      wp_out    <= 1'b1;
    end else begin
      if (clr_cmd) prot_flag <= 1'b0;
      wp_out <= strobe_mode ? (wr_evt && prot_flag) : prot_flag;
    end
  end

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !prot_flag |=> !prot_flag); // R8
  AST_PROT_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_flag) |-> $past(clr_cmd)); // R8
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wp_out && $past(strobe_mode)) |-> $past(wr_evt)); // R10
endmodule

// File: rtl/mem_io_guard.sv
module mem_io_guard
  import mig_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_W = 16,
  parameter int FIELD_LSB = 6,
  parameter logic [CMD_W-1:0] CLR_CMD  = 16'h4003,
  parameter logic [CMD_W-1:0] SPARE_LO = 16'h4800,
  parameter logic [CMD_W-1:0] SPARE_HI = 16'h4FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              io_valid,
  input  logic              io_dir,
  input  logic [CMD_W-1:0]  io_cmd,
  output logic              mem_illegal,
  output logic              io_illegal,
  output logic              wp_out
);
  localparam int NUM_WIN = 2;
  localparam int FIELD_W = CMD_W - FIELD_LSB;
  localparam int CTRL_W  = $bits(guard_ctrl_t);

  guard_ctrl_t        ctrl_q;
  logic [ADDR_W-1:0]  lo_q [NUM_WIN];
  logic [ADDR_W-1:0]  hi_q [NUM_WIN];
  logic [FIELD_W-1:0] thr_out_q;
  logic [FIELD_W-1:0] thr_in_q;
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_hit;
  logic               io_bad;
  logic               prot_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      thr_out_q <= '0;
      thr_in_q  <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL:    ctrl_q    <= guard_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        SEL_LO0:     lo_q[0]   <= cfg_wdata;
        SEL_HI0:     hi_q[0]   <= cfg_wdata;
        SEL_LO1:     lo_q[1]   <= cfg_wdata;
        SEL_HI1:     hi_q[1]   <= cfg_wdata;
        SEL_THR_OUT: thr_out_q <= cfg_wdata[CMD_W-1:FIELD_LSB];
        SEL_THR_IN:  thr_in_q  <= cfg_wdata[CMD_W-1:FIELD_LSB];
        default: ;
      endcase
    end
  end

  always_comb begin
    win_en = {ctrl_q.win1_en, ctrl_q.win0_en};
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mig_window #(.ADDR_W(ADDR_W)) u_win (
      .en   (win_en[w]),
      .lo   (lo_q[w]),
      .hi   (hi_q[w]),
      .addr (mem_addr),
      .hit  (win_hit[w])
    );
  end

  mig_io_check #(
    .CMD_W(CMD_W), .FIELD_LSB(FIELD_LSB),
    .SPARE_LO(SPARE_LO), .SPARE_HI(SPARE_HI)
  ) u_io (
    .io_en    (ctrl_q.io_en),
    .spare_en (ctrl_q.spare_en),
    .dir_out  (io_dir),
    .cmd      (io_cmd),
    .thr_out  (thr_out_q),
    .thr_in   (thr_in_q),
    .illegal  (io_bad)
  );

  mig_protect u_prot (
    .clk         (clk),
    .rst         (rst),
    .clr_cmd     (io_valid && (io_cmd == CLR_CMD)),
    .strobe_mode (ctrl_q.strobe_mode),
    .wr_evt      (mem_valid && mem_write),
    .prot_flag   (prot_flag),
    .wp_out      (wp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_illegal <= 1'b0;
      io_illegal  <= 1'b0;
    end else begin
      mem_illegal <= mem_valid && (|win_hit);
      io_illegal  <= io_valid && io_bad;
    end
  end

  AST_MEM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_illegal |-> $past(mem_valid)); // R11
  AST_IO_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    io_illegal |-> $past(io_valid)); // R11
  AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    mem_illegal |-> $past(ctrl_q.win0_en || ctrl_q.win1_en)); // R3
  AST_IO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    io_illegal |-> $past(ctrl_q.io_en || ctrl_q.spare_en)); // R7
endmodule

// File: tb/sim_mem_io_guard.sv
`timescale 1ns/1ps
module sim_mem_io_guard;
  localparam int ADDR_W = 20;
  localparam int CMD_W = 16;
  localparam logic [15:0] CLR = 16'h4003;
  localparam logic [15:0] SP_LO = 16'h4800;
  localparam logic [15:0] SP_HI = 16'h4FFF;

  logic clk = 1'b0;
  logic rst, cfg_we, mem_valid, mem_write, io_valid, io_dir;
  logic [2:0] cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata, mem_addr;
  logic [CMD_W-1:0] io_cmd;
  logic mem_illegal, io_illegal, wp_out;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [4:0] m_ctrl;
  logic [ADDR_W-1:0] m_lo [2];
  logic [ADDR_W-1:0] m_hi [2];
  logic [9:0] m_tout, m_tin;
  logic m_prot;

  always #2.5 clk = ~clk;

  mem_io_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .io_valid(io_valid), .io_dir(io_dir), .io_cmd(io_cmd),
    .mem_illegal(mem_illegal), .io_illegal(io_illegal), .wp_out(wp_out)
  );

  function automatic logic exp_mem(input logic v, input logic [ADDR_W-1:0] a);
    logic h0, h1;
    h0 = m_ctrl[0] && a >= m_lo[0] && a <= m_hi[0];
    h1 = m_ctrl[1] && a >= m_lo[1] && a <= m_hi[1];
    return v && (h0 || h1);
  endfunction

  function automatic logic exp_io(input logic v, input logic d, input logic [15:0] c);
    logic [9:0] f, t;
    f = c[15:6];
    t = d ? m_tout : m_tin;
    return v && ((m_ctrl[2] && f >= t) || (m_ctrl[3] && c >= SP_LO && c <= SP_HI));
  endfunction

  task automatic check(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    mem_valid = 0; mem_write = 0; mem_addr = 0;
    io_valid = 0; io_dir = 0; io_cmd = 0;
  endtask

  // one clock: predict from current inputs and model, then check
  task automatic step(input string tm, input string ti, input string tw);
    logic em, ei, ew;
    em = exp_mem(mem_valid, mem_addr);
    ei = exp_io(io_valid, io_dir, io_cmd);
    ew = m_ctrl[4] ? (mem_valid && mem_write && m_prot) : m_prot;
    @(posedge clk); #1;
    check(tm, mem_illegal, em);
    check(ti, io_illegal, ei);
    check(tw, wp_out, ew);
    if (io_valid && io_cmd == CLR) m_prot = 0;
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: m_ctrl = cfg_wdata[4:0];
        3'd1: m_lo[0] = cfg_wdata;
        3'd2: m_hi[0] = cfg_wdata;
        3'd3: m_lo[1] = cfg_wdata;
        3'd4: m_hi[1] = cfg_wdata;
        3'd5: m_tout = cfg_wdata[15:6];
        3'd6: m_tin = cfg_wdata[15:6];
        default: ;
      endcase
    end
    idle();
  endtask

  task automatic do_reset();
    idle(); rst = 1;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    m_ctrl = 0; m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
    m_tout = 0; m_tin = 0; m_prot = 1;
    check("R1 mem", mem_illegal, 1'b0);
    check("R1 io", io_illegal, 1'b0);
    check("R1 wp", wp_out, 1'b1);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [ADDR_W-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    step("R12 mem", "R12 io", "R12 wp");
  endtask

  task automatic mem(input logic w, input logic [ADDR_W-1:0] a, input string t);
    mem_valid = 1; mem_write = w; mem_addr = a;
    step(t, "R11 io", t);
  endtask

  task automatic io(input logic d, input logic [15:0] c, input string t);
    io_valid = 1; io_dir = d; io_cmd = c;
    step("R11 mem", t, t);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1757));
    do_reset();
    step("R11 mem", "R11 io", "R1 wp");
    // windows
    cfg(3'd1, 20'h10000); cfg(3'd2, 20'h1FFFF);
    cfg(3'd3, 20'h80000); cfg(3'd4, 20'h80FFF);
    mem(0, 20'h10000, "R3 disabled");
    cfg(3'd0, 5'b00001);
    mem(0, 20'h10000, "R2 low bound");
    mem(0, 20'h1FFFF, "R2 high bound");
    mem(0, 20'h0FFFF, "R2 below");
    mem(0, 20'h20000, "R2 above");
    mem(0, 20'h80000, "R3 win1 off");
    cfg(3'd0, 5'b00011);
    mem(0, 20'h80FFF, "R3 win1 on");
    mem(0, 20'h81000, "R3 win1 above");
    step("R11 mem idle", "R11 io idle", "R9 wp");
    // I/O thresholds
    cfg(3'd5, 20'h02000); cfg(3'd6, 20'h01000);
    cfg(3'd0, 5'b00111);
    io(1, 16'h1FC0, "R4 below");
    io(1, 16'h2000, "R4 at thr");
    io(0, 16'h1000, "R5 in at thr");
    io(0, 16'h0FC0, "R5 in below");
    io(0, 16'h1FC0, "R5 uses in thr");
    cfg(3'd0, 5'b00011);
    io(1, 16'h3000, "R7 disabled");
    cfg(3'd0, 5'b01011);
    io(1, 16'h4800, "R6 spare low");
    io(0, 16'h4FFF, "R6 spare high");
    io(0, 16'h5000, "R6 outside");
    // write protect
    cfg(3'd0, 5'b10011);
    mem(1, 20'h00100, "R10 write strobe");
    mem(0, 20'h00100, "R10 read no strobe");
    step("R11 mem", "R11 io", "R10 idle");
    cfg(3'd0, 5'b00011);
    step("R11 mem", "R11 io", "R9 level");
    io(1, 16'h4004, "R8 other cmd");
    io(0, CLR, "R8 clear cmd");
    step("R11 mem", "R11 io", "R8 cleared");
    io(1, 16'h0000, "R8 sticky");
    cfg(3'd0, 5'b10011);
    mem(1, 20'h00200, "R10 no strobe when clear");
    // random phase
    do_reset();
    for (int k = 0; k < 2000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        cfg_we = 1;
        cfg_sel = 3'($urandom_range(0, 6));
        cfg_wdata = (cfg_sel == 3'd0) ? 20'($urandom_range(0, 31)) :
                    20'($urandom_range(0, 20'hFFFFF));
      end
      mem_valid = $urandom_range(0, 1);
      mem_write = $urandom_range(0, 1);
      mem_addr = ($urandom_range(0, 3) == 0) ? m_lo[$urandom_range(0, 1)] :
                 ($urandom_range(0, 3) == 0) ? m_hi[$urandom_range(0, 1)] :
                 20'($urandom_range(0, 20'hFFFFF));
      io_valid = $urandom_range(0, 1);
      io_dir = $urandom_range(0, 1);
      io_cmd = ($urandom_range(0, 3) == 0) ? {m_tout, 6'($urandom_range(0, 63))} :
               ($urandom_range(0, 63) == 0) ? CLR :
               16'($urandom_range(0, 16'hFFFF));
      step("RAND-R2", "RAND-R4", "RAND-R9");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule